// File: doc/BRIEF.md
# Rotating Priority Interrupt Core

This block gathers eight interrupt request lines, keeps which of them are pending, masked and being serviced, and decides whether the processor should be interrupted. Priority is rotational. A 3-bit offset names the input that currently holds the best rank. Rank p is input (p + offset) mod 8. Each input can be edge or level triggered, as set by a per-line trigger select register.

An interrupt is requested only when the best unmasked pending input ranks strictly better than the best input in service. When the processor pulses the acknowledge strobe, the core marks the winner as in service. In automatic end-of-interrupt mode it instead leaves the in-service register alone, and can rotate the offset. An 8-bit vector is returned, made of a 5-bit base and the 3-bit input number. A separate command decoder drives the register load ports and the end-of-interrupt commands. Two options change the in-service comparison. A fully nested option, used on the master instance only, takes the cascade input out of it. A special mask option drops masked in-service inputs from it.

Top module: `prio_irq_core`

## Requirements
- R1: A line in edge mode (trigger bit 0) sets its request bit on the first clock where it is sampled high after being sampled low. The request stays set while the line is low, until an acknowledge clears it.
- R2: A line in level mode (trigger bit 1) has its request bit equal to the line level sampled at the last clock. An acknowledge does not clear it.
- R3: Rank p belongs to input (p + offset) mod 8, and the lowest rank wins. After reset the offset is 0. The set-lowest command (cmd_op 2) loads offset = cmd_lvl + 1.
- R4: int_req is high only when the best rank of (request AND NOT mask) is strictly less than the best in-service rank. Equal ranks give no request, and masked requests never count.
- R5: With the fully nested option (cfg_d bit 2) on a master instance, input 2 is left out of the in-service set used by R4.
- R6: With the special mask option (cfg_d bit 3), in-service bits whose mask bit is set are left out of the in-service set used by R4.
- R7: An acknowledge while int_req is high sets the winner's in-service bit, unless automatic end-of-interrupt is on (cfg_d bit 0). With cfg_d bit 1 also on, the acknowledge instead sets offset = winner + 1.
- R8: An acknowledge clears the winner's request bit in edge mode. A new rising edge on that line in the same cycle wins, and the request stays set.
- R9: vector is {base, input}. The input is the winner while int_req is high, and 7 (spurious) otherwise.
- R10: cmd_op 0 clears the best-ranked in-service bit. cmd_op 1 clears in-service bit cmd_lvl. With cmd_rot set, either command also sets offset = cleared input + 1. cmd_op 3 does nothing.
- R11: Reset clears the request, mask and in-service registers, the offset, the base and all options. The trigger select register keeps its value.
- R12: int_req and vector are combinational from the registers. They reflect any register update from the clock edge that made it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Raw interrupt request lines |
| ack | input | 1 | Acknowledge strobe, one cycle |
| vector | output | 8 | Vector an acknowledge in this cycle returns |
| int_req | output | 1 | Interrupt request to the processor |
| mask_we | input | 1 | Load the mask register |
| mask_d | input | 8 | Mask value, 1 masks the input |
| trig_we | input | 1 | Load the trigger select register |
| trig_d | input | 8 | Trigger select, 1 = level, 0 = edge |
| base_we | input | 1 | Load the vector base |
| base_d | input | 5 | Vector base (upper 5 bits) |
| cfg_we | input | 1 | Load the option bits |
| cfg_d | input | 4 | bit0 auto EOI, bit1 rotate on auto EOI, bit2 fully nested, bit3 special mask |
| cmd_we | input | 1 | Issue an end-of-interrupt or priority command |
| cmd_op | input | 2 | 0 clear best in service, 1 clear given level, 2 set lowest, 3 none |
| cmd_rot | input | 1 | Rotate the offset with an end-of-interrupt command |
| cmd_lvl | input | 3 | Input number for commands 1 and 2 |

## Verification
The delicate overlap is an acknowledge that lands in the same cycle as a fresh rising edge on the input being acknowledged. The clear from the acknowledge and the set from the edge then hit one request bit together. The bench forces this by pulsing the line, dropping it, and raising it again exactly in the acknowledge cycle. It then clears the in-service bit with a specific end-of-interrupt command and expects the same input's vector again, which proves the request survived. The random phase also lets acknowledges meet end-of-interrupt commands and mask writes in one cycle, and it judges every cycle against a reference model built from the requirements.

// File: rtl/pic_core_pkg.sv
package pic_core_pkg;

  typedef enum logic [1:0] {
    CMD_EOI_TOP = 2'd0,
    CMD_EOI_LVL = 2'd1,
    CMD_SET_LOW = 2'd2,
    CMD_NOP     = 2'd3
  } cmd_op_e;

  typedef struct packed {
    logic smm;       // special mask: drop masked in-service bits
    logic sfnm;      // fully nested: drop cascade input
    logic rot_aeoi;  // rotate offset on automatic EOI
    logic aeoi;      // automatic end of interrupt
  } mode_t;

endpackage

// File: rtl/pic_rank.sv
module pic_rank #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int RW = 4
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] off,
  output logic [RW-1:0] rank
);

  logic [N-1:0] rot;

  for (genvar p = 0; p < N; p++) begin : g_rot
    logic [IW-1:0] src;
    assign src    = IW'(p) + off;
    assign rot[p] = req[src];
  end

  always_comb begin
    rank = RW'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (rot[p]) rank = RW'(p);
    end
  end

endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr_q,
  output logic [N-1:0] last_q
);

  logic [N-1:0] irr_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign irr_d[i] = trig[i] ? line[i]
                              : ((irr_q[i] & ~clr[i]) | (line[i] & ~last_q[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      last_q <= '0;
    end else begin
      irr_q  <= irr_d;
      last_q <= line;
    end
  end

endmodule

// File: rtl/prio_irq_core.sv
module prio_irq_core
  import pic_core_pkg::*;
#(
  parameter int N_IN       = 8,
  parameter int VEC_W      = 8,
  parameter bit IS_MASTER  = 1'b1,
  parameter int CASCADE_IN = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_IN-1:0]               irq_in,
  input  logic                          ack,
  output logic [VEC_W-1:0]              vector,
  output logic                          int_req,
  input  logic                          mask_we,
  input  logic [N_IN-1:0]               mask_d,
  input  logic                          trig_we,
  input  logic [N_IN-1:0]               trig_d,
  input  logic                          base_we,
  input  logic [VEC_W-$clog2(N_IN)-1:0] base_d,
  input  logic                          cfg_we,
  input  logic [3:0]                    cfg_d,
  input  logic                          cmd_we,
  input  logic [1:0]                    cmd_op,
  input  logic                          cmd_rot,
  input  logic [$clog2(N_IN)-1:0]       cmd_lvl
);

  localparam int IW = $clog2(N_IN);
  localparam int RW = IW + 1;
  localparam int BW = VEC_W - IW;

  logic [N_IN-1:0] irr_q, last_q, imr_q, isr_q, trig_q;
  logic [N_IN-1:0] imr_d, isr_d, svc_mask, pick_oh, isr_set, isr_clr;
  logic [IW-1:0]   off_q, off_d, pend_idx, top_idx;
  logic [BW-1:0]   base_q, base_n;
  mode_t           mode_q, mode_d;
  logic [RW-1:0]   pend_rank, svc_rank, top_rank;
  logic            take, top_hit;

  pic_req_latch #(.N(N_IN)) u_latch (
    .clk(clk), .rst_n(rst_n), .line(irq_in), .trig(trig_q),
    .clr(pick_oh), .irr_q(irr_q), .last_q(last_q)
  );

  pic_rank #(.N(N_IN), .IW(IW), .RW(RW)) u_pend (
    .req(irr_q & ~imr_q), .off(off_q), .rank(pend_rank)
  );

  pic_rank #(.N(N_IN), .IW(IW), .RW(RW)) u_svc (
    .req(svc_mask), .off(off_q), .rank(svc_rank)
  );

  pic_rank #(.N(N_IN), .IW(IW), .RW(RW)) u_top (
    .req(isr_q), .off(off_q), .rank(top_rank)
  );

  always_comb begin
    svc_mask = isr_q;
    if (mode_q.smm) svc_mask = svc_mask & ~imr_q;
    if (IS_MASTER && mode_q.sfnm) svc_mask[CASCADE_IN] = 1'b0;
  end

  assign pend_idx = pend_rank[IW-1:0] + off_q;
  assign top_idx  = top_rank[IW-1:0] + off_q;
  assign top_hit  = ~top_rank[IW];
  assign int_req  = (pend_rank < svc_rank);
  assign take     = ack & int_req;
  assign pick_oh  = take ? (N_IN'(1) << pend_idx) : '0;
  assign vector   = {base_q, (int_req ? pend_idx : IW'(N_IN - 1))};

  // next state
  always_comb begin
    isr_set = (take && !mode_q.aeoi) ? pick_oh : '0;
    isr_clr = '0;
    off_d   = off_q;
    if (take && mode_q.aeoi && mode_q.rot_aeoi) off_d = pend_idx + 1'b1;
    if (cmd_we) begin
      case (cmd_op_e'(cmd_op))
        CMD_EOI_TOP: if (top_hit) begin
          isr_clr = N_IN'(1) << top_idx;
          if (cmd_rot) off_d = top_idx + 1'b1;
        end
        CMD_EOI_LVL: begin
          isr_clr = N_IN'(1) << cmd_lvl;
          if (cmd_rot) off_d = cmd_lvl + 1'b1;
        end
        CMD_SET_LOW: off_d = cmd_lvl + 1'b1;
        default: ;
      endcase
    end
    isr_d  = (isr_q | isr_set) & ~isr_clr;
    imr_d  = mask_we ? mask_d : imr_q;
    base_n = base_we ? base_d : base_q;
    mode_d = cfg_we ? mode_t'(cfg_d) : mode_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q  <= '0;
      isr_q  <= '0;
      off_q  <= '0;
      base_q <= '0;
      mode_q <= '0;
    end else begin
      imr_q  <= imr_d;
      isr_q  <= isr_d;
      off_q  <= off_d;
      base_q <= base_n;
      mode_q <= mode_d;
    end
  end

  // trigger select survives reset
  always_ff @(posedge clk) begin
    if (trig_we) trig_q <= trig_d;
  end

endmodule

// File: rtl/prio_irq_core_chk.sv
module prio_irq_core_chk #(
  parameter int N_IN  = 8,
  parameter int IW    = 3,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             int_req,
  input logic [N_IN-1:0]  irq_in,
  input logic [N_IN-1:0]  irr_q,
  input logic [N_IN-1:0]  last_q,
  input logic [N_IN-1:0]  isr_q,
  input logic [N_IN-1:0]  imr_q,
  input logic [N_IN-1:0]  trig_q,
  input logic [IW-1:0]    off_q,
  input logic [IW-1:0]    pend_idx,
  input logic             aeoi,
  input logic             rot_aeoi,
  input logic             cmd_we,
  input logic [VEC_W-1:0] vector
);

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(irq_in) & ~$past(last_q) & ~$past(trig_q)) & ~irr_q) == '0); // R1

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((irr_q ^ $past(irq_in)) & $past(trig_q)) == '0); // R2

  AST_NO_PENDING_NO_INT: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_q & ~imr_q) == '0) |-> !int_req); // R4

  AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_req && !aeoi && !cmd_we) |=> isr_q[$past(pend_idx)]); // R7

  AST_AEOI_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_req && aeoi && rot_aeoi && !cmd_we) |=> off_q == IW'($past(pend_idx) + 1'b1)); // R7

  AST_ACK_CLEARS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_req && !trig_q[pend_idx] && !(irq_in[pend_idx] && !last_q[pend_idx]))
      |=> !irr_q[$past(pend_idx)]); // R8

  AST_SPURIOUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !int_req |-> vector[IW-1:0] == IW'(N_IN - 1)); // R9

endmodule

bind prio_irq_core prio_irq_core_chk #(.N_IN(N_IN), .IW(IW), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .int_req(int_req), .irq_in(irq_in),
  .irr_q(irr_q), .last_q(last_q), .isr_q(isr_q), .imr_q(imr_q), .trig_q(trig_q),
  .off_q(off_q), .pend_idx(pend_idx), .aeoi(mode_q.aeoi), .rot_aeoi(mode_q.rot_aeoi),
  .cmd_we(cmd_we), .vector(vector)
);

// File: tb/tb_prio_irq_core.sv
module tb_prio_irq_core;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       ack;
  logic [7:0] vector;
  logic       int_req;
  logic       mask_we, trig_we, base_we, cfg_we, cmd_we, cmd_rot;
  logic [7:0] mask_d, trig_d;
  logic [4:0] base_d;
  logic [3:0] cfg_d;
  logic [1:0] cmd_op;
  logic [2:0] cmd_lvl;

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  logic [7:0] m_irr, m_last, m_imr, m_isr, m_trig;
  logic [2:0] m_off;
  logic [4:0] m_base;
  logic [3:0] m_cfg;

  always #10 clk = ~clk;

  prio_irq_core dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack), .vector(vector),
    .int_req(int_req), .mask_we(mask_we), .mask_d(mask_d), .trig_we(trig_we),
    .trig_d(trig_d), .base_we(base_we), .base_d(base_d), .cfg_we(cfg_we),
    .cfg_d(cfg_d), .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_rot(cmd_rot),
    .cmd_lvl(cmd_lvl)
  );

  function automatic int rank8(input logic [7:0] m, input logic [2:0] off);
    for (int p = 0; p < 8; p++) begin
      logic [2:0] s;
      s = 3'(p) + off;
      if (m[s]) return p;
    end
    return 8;
  endfunction

  task automatic model_eval(output logic intr, output logic [2:0] idx);
    logic [7:0] svc;
    int pr, sr;
    pr  = rank8(m_irr & ~m_imr, m_off);
    svc = m_isr;
    if (m_cfg[3]) svc = svc & ~m_imr;
    if (m_cfg[2]) svc[2] = 1'b0;
    sr   = rank8(svc, m_off);
    intr = (pr < sr);
    idx  = 3'(pr) + m_off;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_strobes();
    ack = 0; mask_we = 0; trig_we = 0; base_we = 0; cfg_we = 0; cmd_we = 0;
    cmd_rot = 0; cmd_op = 2'd3;
  endtask

  // one clock: check outputs against model, advance model and design
  task automatic cyc();
    logic ei;
    logic [2:0] ei_idx;
    logic [7:0] n_irr, n_isr, clr, iset, iclr;
    logic [2:0] n_off;
    int tr;
    model_eval(ei, ei_idx);
    chk(int_req === ei, "R12", {7'd0, int_req}, {7'd0, ei});
    chk(vector === {m_base, (ei ? ei_idx : 3'd7)}, "R9", vector, {m_base, (ei ? ei_idx : 3'd7)});
    clr = 0; iset = 0; iclr = 0; n_off = m_off;
    if (ack && ei) begin
      clr = 8'd1 << ei_idx;
      if (!m_cfg[0]) iset = clr;
      else if (m_cfg[1]) n_off = ei_idx + 3'd1;
    end
    for (int i = 0; i < 8; i++)
      n_irr[i] = m_trig[i] ? irq_in[i] : ((m_irr[i] & ~clr[i]) | (irq_in[i] & ~m_last[i]));
    if (cmd_we) begin
      if (cmd_op == 2'd0) begin
        tr = rank8(m_isr, m_off);
        if (tr < 8) begin
          iclr = 8'd1 << (3'(tr) + m_off);
          if (cmd_rot) n_off = 3'(tr) + m_off + 3'd1;
        end
      end else if (cmd_op == 2'd1) begin
        iclr = 8'd1 << cmd_lvl;
        if (cmd_rot) n_off = cmd_lvl + 3'd1;
      end else if (cmd_op == 2'd2) begin
        n_off = cmd_lvl + 3'd1;
      end
    end
    n_isr = (m_isr | iset) & ~iclr;
    @(posedge clk);
    m_irr = n_irr; m_last = irq_in; m_isr = n_isr; m_off = n_off;
    if (mask_we) m_imr = mask_d;
    if (trig_we) m_trig = trig_d;
    if (base_we) m_base = base_d;
    if (cfg_we)  m_cfg = cfg_d;
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_irr = 0; m_last = 0; m_imr = 0; m_isr = 0; m_off = 0; m_base = 0; m_cfg = 0;
    @(posedge clk);
    if (trig_we) m_trig = trig_d;
    @(negedge clk);
    clear_strobes();
    rst_n = 1;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    clear_strobes();
    irq_in = 0; mask_d = 0; trig_d = 0; base_d = 0; cfg_d = 0; cmd_lvl = 0;
    m_trig = 0;
    trig_we = 1;
    @(negedge clk);
    do_reset();

    // R11: reset state
    chk(int_req === 1'b0, "R11", {7'd0, int_req}, 8'h00);
    chk(vector === 8'h07, "R11", vector, 8'h07);

    base_we = 1; base_d = 5'd2; cyc();
    chk(vector === 8'h17, "R9", vector, 8'h17);

    irq_in = 8'h08; cyc();                               // R1 edge on input 3
    chk(int_req === 1'b1 && vector === 8'h13, "R1", vector, 8'h13);

    chk(vector === 8'h13, "R9", vector, 8'h13);          // vector seen during ack
    ack = 1; cyc();
    chk(int_req === 1'b0, "R7", {7'd0, int_req}, 8'h00);

    irq_in = 8'h00; cyc();
    irq_in = 8'h08; cyc();                               // equal rank: no request
    chk(int_req === 1'b0, "R4", {7'd0, int_req}, 8'h00);

    irq_in = 8'h0A; cyc();
    chk(vector === 8'h11 && int_req, "R3", vector, 8'h11);

    ack = 1; cyc();
    cmd_we = 1; cmd_op = 2'd0; cyc();
    chk(int_req === 1'b0, "R10", {7'd0, int_req}, 8'h00);
    cmd_we = 1; cmd_op = 2'd0; cyc();
    chk(int_req === 1'b1 && vector === 8'h13, "R10", vector, 8'h13);

    // level mode on input 5
    irq_in = 8'h00; trig_we = 1; trig_d = 8'h20; cyc();
    irq_in = 8'h20; cyc();
    chk(vector === 8'h13, "R3", vector, 8'h13);
    mask_we = 1; mask_d = 8'h08; cyc();
    chk(vector === 8'h15, "R4", vector, 8'h15);
    ack = 1; cyc();
    irq_in = 8'h00; cyc();
    cmd_we = 1; cmd_op = 2'd0; cyc();
    chk(int_req === 1'b0, "R2", {7'd0, int_req}, 8'h00);
    irq_in = 8'h20; cyc();
    chk(int_req === 1'b1 && vector === 8'h15, "R2", vector, 8'h15);
    irq_in = 8'h00; cyc();
    chk(int_req === 1'b0, "R2", {7'd0, int_req}, 8'h00);

    // rotation: input 4 lowest, offset 5
    mask_we = 1; mask_d = 8'h00; cmd_we = 1; cmd_op = 2'd2; cmd_lvl = 3'd4; cyc();
    irq_in = 8'h01; cyc();
    chk(vector === 8'h10, "R3", vector, 8'h10);

    // automatic EOI with rotation
    cfg_we = 1; cfg_d = 4'b0011; cyc();
    ack = 1; cyc();
    irq_in = 8'h00; cyc();
    irq_in = 8'h01; cyc();
    chk(vector === 8'h13, "R7", vector, 8'h13);
    cfg_we = 1; cfg_d = 4'b0001; cyc();
    ack = 1; cyc();
    chk(int_req === 1'b1 && vector === 8'h10, "R7", vector, 8'h10);

    // trigger select kept through reset
    irq_in = 8'h00; cyc();
    do_reset();
    irq_in = 8'h20; cyc();
    irq_in = 8'h00; cyc();
    chk(int_req === 1'b0, "R11", {7'd0, int_req}, 8'h00);

    // fully nested: cascade input excluded
    cfg_we = 1; cfg_d = 4'b0100; cyc();
    irq_in = 8'h04; cyc();
    ack = 1; cyc();
    irq_in = 8'h00; cyc();
    irq_in = 8'h04; cyc();
    chk(int_req === 1'b1 && vector === 8'h02, "R5", vector, 8'h02);

    // special mask
    cfg_we = 1; cfg_d = 4'b1000; cyc();
    chk(int_req === 1'b0, "R6", {7'd0, int_req}, 8'h00);
    mask_we = 1; mask_d = 8'h04; cyc();
    irq_in = 8'h44; cyc();
    chk(int_req === 1'b1 && vector === 8'h06, "R6", vector, 8'h06);
    cfg_we = 1; cfg_d = 4'b0000; cyc();
    chk(int_req === 1'b0, "R6", {7'd0, int_req}, 8'h00);

    // acknowledge meets a new edge on the same line
    irq_in = 8'h00; cyc();
    do_reset();
    irq_in = 8'h10; cyc();
    irq_in = 8'h00; cyc();
    ack = 1; irq_in = 8'h10; cyc();
    cmd_we = 1; cmd_op = 2'd1; cmd_lvl = 3'd4; cyc();
    chk(int_req === 1'b1 && vector === 8'h04, "R8", vector, 8'h04);

    // constrained random phase
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < 8; b++)
        if ($urandom_range(0, 5) == 0) irq_in[b] = ~irq_in[b];
      ack = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 7) == 0) begin
        cmd_we = 1; cmd_op = 2'($urandom_range(0, 3));
        cmd_rot = 1'($urandom_range(0, 1)); cmd_lvl = 3'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 9) == 0)  begin mask_we = 1; mask_d = 8'($urandom); end
      if ($urandom_range(0, 15) == 0) begin cfg_we = 1;  cfg_d = 4'($urandom); end
      if ($urandom_range(0, 31) == 0) begin trig_we = 1; trig_d = 8'($urandom); end
      if ($urandom_range(0, 31) == 0) begin base_we = 1; base_d = 5'($urandom); end
      if (n == 1500) do_reset();
      else cyc();
    end

    report();
  end

endmodule